// File: doc/BRIEF.md
# Sector Erase Command Decoder

This block is the command front end of a NOR-style flash device. It watches host write cycles, each presented as an address, a data byte and a single-cycle pulse marking the rising edge of the write strobe. It recognises the six-cycle sector-erase command and the chip-erase command. After a sector-erase command it keeps an acceptance window open, and further sector writes extend that window. When the window lapses, the block issues a one-cycle start request to the erase engine. The request carries a bitmask of the selected sectors.

The window restarts on every sector the host adds. One command can therefore gather any subset of sectors, in any order, as long as the host writes each new sector before the window expires. Once the request has been issued, the block reports busy and ignores the host until the erase engine signals completion. It then returns to read-array mode.

Top module: `erase_cmd_decoder`

## Requirements
- R1: After reset, `erase_start`, `busy` and `win_open` are low and `erase_mask` is zero.
- R2: A sector-erase command consists of six writes. The fixed pairs, given as low-11-bit address/data, are 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA and 0x2AA/0x55. The sixth write has data 0x30 and any address. The sixth write opens the window (`win_open` high) and sets the mask bit whose index is the sector number in address bits [11:8].
- R3: `erase_start` rises exactly TMO_CYC cycles after the write edge of the last accepted sector. It is high for exactly one cycle, and `busy` rises with it.
- R4: Each write of data 0x30 while the window is open adds its sector to the mask, in any order and with repeats allowed, and restarts the window count.
- R5: A sector write that lands on the expiry edge, or on any later edge, is not part of the command. The mask issued with `erase_start` excludes it.
- R6: Any write with data other than 0x30 while the window is open closes the window, clears the mask and returns to read mode. No `erase_start` follows.
- R7: A write that breaks the fixed pattern in cycles one to five returns the decoder to read mode. The remaining cycles of that attempt then open no window.
- R8: A sixth write of 0x555/0x10 is a chip-erase command. On that edge `erase_start` rises with an all-ones mask, and no window opens.
- R9: `busy` stays high, and `erase_mask` stays unchanged, until `erase_done` is seen. Host writes during busy have no effect. After `erase_done`, `busy` falls and a new command is accepted.
- R10: `erase_done` while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_pulse | input | 1 | One-cycle pulse marking the rising edge of a host write strobe |
| wr_addr | input | ADDR_W | Address of the host write |
| wr_data | input | 8 | Data byte of the host write |
| erase_done | input | 1 | Completion indication from the erase engine |
| erase_start | output | 1 | One-cycle request to start erasing |
| erase_mask | output | 2**SECT_W | Sectors selected for erasure |
| busy | output | 1 | High from erase_start until erase_done |
| win_open | output | 1 | Sector acceptance window open |

## Verification
The hardest situation to reach from the ports is a sector write that coincides with window expiry, or that arrives one cycle before it. Directed stimulus places extra sector writes exactly TMO_CYC-1 and TMO_CYC cycles after the previous accepted write. It then checks that the first write is absorbed and the second is dropped. Random runs gather up to six sectors with gaps drawn from the full legal range. They also vary the delay before `erase_done` and inject writes during busy.

// File: rtl/fec_pkg.sv
package fec_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_C1, ST_C2, ST_C3, ST_C4, ST_C5, ST_WIN, ST_BUSY
  } fec_state_t;

  localparam logic [7:0] CODE_UNLK1 = 8'hAA;
  localparam logic [7:0] CODE_UNLK2 = 8'h55;
  localparam logic [7:0] CODE_SETUP = 8'h80;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_CHIP  = 8'h10;

  localparam int UNLK_ADDR1 = 'h555;
  localparam int UNLK_ADDR2 = 'h2AA;
endpackage

// File: rtl/fec_cycle_decode.sv
module fec_cycle_decode #(
  parameter int ADDR_W = 12,
  parameter int CMD_AW = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              is_u1,
  output logic              is_u2,
  output logic              is_setup,
  output logic              is_sect,
  output logic              is_chip
);
  import fec_pkg::*;

  localparam logic [CMD_AW-1:0] A1 = CMD_AW'(UNLK_ADDR1);
  localparam logic [CMD_AW-1:0] A2 = CMD_AW'(UNLK_ADDR2);

  logic [CMD_AW-1:0] low;
  logic at_a1, at_a2;

  always_comb begin
    low      = addr[CMD_AW-1:0];
    at_a1    = (low == A1);
    at_a2    = (low == A2);
    is_u1    = at_a1 && (data == CODE_UNLK1);
    is_u2    = at_a2 && (data == CODE_UNLK2);
    is_setup = at_a1 && (data == CODE_SETUP);
    is_chip  = at_a1 && (data == CODE_CHIP);
    is_sect  = (data == CODE_SECT);
  end
endmodule

// File: rtl/fec_window_timer.sv
module fec_window_timer #(
  parameter int TMO_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= RELOAD;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/fec_sector_buffer.sv
module fec_sector_buffer #(
  parameter int SECT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 load,
  input  logic                 add,
  input  logic                 set_all,
  input  logic [SECT_W-1:0]    idx,
  output logic [(1<<SECT_W)-1:0] mask
);
  localparam int NS = 1 << SECT_W;

  for (genvar i = 0; i < NS; i++) begin : g_bit
    logic hit;
    assign hit = (idx == SECT_W'(i));
    always_ff @(posedge clk) begin
      if (rst || clr)   mask[i] <= 1'b0;
      else if (set_all) mask[i] <= 1'b1;
      else if (load)    mask[i] <= hit;
      else if (add)     mask[i] <= mask[i] | hit;
    end
  end
endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder #(
  parameter int ADDR_W  = 12,
  parameter int CMD_AW  = 11,
  parameter int SECT_W  = 4,
  parameter int TMO_CYC = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_pulse,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   erase_done,
  output logic                   erase_start,
  output logic [(1<<SECT_W)-1:0] erase_mask,
  output logic                   busy,
  output logic                   win_open
);
  import fec_pkg::*;

  fec_state_t state;
  logic is_u1, is_u2, is_setup, is_sect, is_chip;
  logic tmr_exp, buf_load, buf_add, buf_all, buf_clr;
  logic [SECT_W-1:0] sect_idx;

  assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];

  fec_cycle_decode #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW)) u_dec (
    .addr(wr_addr), .data(wr_data),
    .is_u1(is_u1), .is_u2(is_u2), .is_setup(is_setup),
    .is_sect(is_sect), .is_chip(is_chip)
  );

  always_comb begin
    buf_load = (state == ST_C5) && wr_pulse && is_sect;
    buf_all  = (state == ST_C5) && wr_pulse && is_chip;
    buf_add  = (state == ST_WIN) && wr_pulse && is_sect && !tmr_exp;
    buf_clr  = (state == ST_WIN) && wr_pulse && !is_sect && !tmr_exp;
  end

  fec_window_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst(rst),
    .load(buf_load || buf_add),
    .run(state == ST_WIN),
    .expired(tmr_exp)
  );

  fec_sector_buffer #(.SECT_W(SECT_W)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .load(buf_load),
    .add(buf_add), .set_all(buf_all), .idx(sect_idx), .mask(erase_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_READ;
      erase_start <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      case (state)
        ST_READ: if (wr_pulse && is_u1) state <= ST_C1;
        ST_C1:   if (wr_pulse) state <= is_u2    ? ST_C2 : ST_READ;
        ST_C2:   if (wr_pulse) state <= is_setup ? ST_C3 : ST_READ;
        ST_C3:   if (wr_pulse) state <= is_u1    ? ST_C4 : ST_READ;
        ST_C4:   if (wr_pulse) state <= is_u2    ? ST_C5 : ST_READ;
        ST_C5: if (wr_pulse) begin
          if (is_sect) state <= ST_WIN;
          else if (is_chip) begin
            state       <= ST_BUSY;
            erase_start <= 1'b1;
          end else state <= ST_READ;
        end
        ST_WIN: begin
          if (tmr_exp) begin
            state       <= ST_BUSY;
            erase_start <= 1'b1;
          end else if (wr_pulse && !is_sect) state <= ST_READ;
        end
        ST_BUSY: if (erase_done) state <= ST_READ;
        default: state <= ST_READ;
      endcase
    end
  end

  assign busy     = (state == ST_BUSY);
  assign win_open = (state == ST_WIN);
endmodule

// File: rtl/erase_cmd_decoder_chk.sv
module erase_cmd_decoder_chk #(
  parameter int NS = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_pulse,
  input logic [7:0]    wr_data,
  input logic          erase_done,
  input logic          erase_start,
  input logic [NS-1:0] erase_mask,
  input logic          busy,
  input logic          win_open
);
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);
  assert_busy_with_start_R3: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> busy);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy && !erase_done |=> busy);
  assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
    busy && erase_done |=> !busy);
  assert_mask_stable_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(erase_mask));
  assert_no_window_busy_R6: assert property (@(posedge clk) disable iff (rst)
    !(win_open && busy));
  assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
    win_open && wr_pulse && wr_data != 8'h30 && !erase_start |=> !win_open);
  assert_start_mask_R4: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> erase_mask != '0);
  assert_window_mask_R2: assert property (@(posedge clk) disable iff (rst)
    win_open |-> $countones(erase_mask) > 0);
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (rst)
    !busy && !erase_start |=> !busy || erase_start);
endmodule

bind erase_cmd_decoder erase_cmd_decoder_chk #(.NS(1 << SECT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .wr_data(wr_data),
  .erase_done(erase_done), .erase_start(erase_start),
  .erase_mask(erase_mask), .busy(busy), .win_open(win_open)
);

// File: tb/erase_cmd_decoder_bench.sv
module erase_cmd_decoder_bench;
  localparam int AW = 12;
  localparam int SW = 4;
  localparam int NS = 1 << SW;
  localparam int T  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_pulse = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic erase_done = 1'b0;
  logic erase_start, busy, win_open;
  logic [NS-1:0] erase_mask;

  int n_chk = 0;
  int n_bad = 0;
  int starts = 0;

  always #4 clk = ~clk;

  erase_cmd_decoder #(.ADDR_W(AW), .CMD_AW(11), .SECT_W(SW), .TMO_CYC(T)) u_erase_cmd_decoder (
    .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .erase_done(erase_done), .erase_start(erase_start),
    .erase_mask(erase_mask), .busy(busy), .win_open(win_open)
  );

  always @(negedge clk) if (erase_start) starts++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sect_addr(input int s, input int low);
    return {s[SW-1:0], low[AW-SW-1:0]};
  endfunction

  function automatic logic [NS-1:0] bit_of(input int s);
    return NS'(1) << s;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_pulse = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_pulse = 1'b0;
  endtask

  task automatic prefix5();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  // called right after the last accepted sector write returned
  task automatic expect_start(input string req, input logic [NS-1:0] m);
    int early = 0;
    for (int i = 1; i < T; i++) begin
      @(negedge clk);
      if (erase_start) early++;
    end
    chk({req, " no early start"}, early, 0);
    @(negedge clk);
    chk({req, " start on time"}, {busy, erase_start}, 2'b11);
    chk({req, " mask"}, erase_mask, m);
    @(negedge clk);
    chk({req, " one-cycle pulse"}, {busy, erase_start}, 2'b10);
  endtask

  task automatic finish_erase(input int dly);
    repeat (dly) @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    chk("R9 busy released", busy, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s0, s1, st;
    logic [NS-1:0] m;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {erase_start, busy, win_open}, 3'b000);
    chk("R1 reset mask", erase_mask, 0);

    // R10: done while idle
    erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    chk("R10 done idle", {busy, erase_start}, 2'b00);

    // R2 + R3: single sector
    prefix5();
    wr(sect_addr(5, 8'h12), 8'h30);
    chk("R2 window open", win_open, 1'b1);
    chk("R2 first bit", erase_mask, bit_of(5));
    expect_start("R3 single", bit_of(5));
    // R9: writes during busy ignored
    wr(sect_addr(9, 0), 8'h30); wr(12'h555, 8'hAA);
    chk("R9 busy held", {busy, win_open}, 2'b10);
    chk("R9 mask held", erase_mask, bit_of(5));
    finish_erase(7);

    // R4 + boundary: add at T-1 accepted
    prefix5();
    wr(sect_addr(2, 0), 8'h30);
    repeat (T - 2) @(negedge clk);
    wr(sect_addr(11, 3), 8'h30);
    chk("R4 boundary add", erase_mask, bit_of(2) | bit_of(11));
    expect_start("R4 reload", bit_of(2) | bit_of(11));
    finish_erase(2);

    // R5: write on expiry edge dropped
    prefix5();
    wr(sect_addr(3, 0), 8'h30);
    repeat (T - 1) @(negedge clk);
    wr(sect_addr(8, 0), 8'h30);
    chk("R5 late start", {busy, erase_start}, 2'b11);
    chk("R5 late mask", erase_mask, bit_of(3));
    finish_erase(3);

    // R6: abort
    prefix5();
    wr(sect_addr(4, 0), 8'h30);
    st = starts;
    wr(sect_addr(6, 0), 8'hF0);
    chk("R6 window closed", win_open, 1'b0);
    chk("R6 mask cleared", erase_mask, 0);
    repeat (T + 5) @(negedge clk);
    chk("R6 no start", starts - st, 0);
    chk("R6 not busy", busy, 1'b0);

    // R7: bad setup code, then remainder
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(sect_addr(1, 0), 8'h30);
    chk("R7 bad setup", win_open, 1'b0);
    // R7: bad unlock address
    wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(sect_addr(1, 0), 8'h30);
    chk("R7 bad address", win_open, 1'b0);
    repeat (T + 2) @(negedge clk);
    chk("R7 no start", busy, 1'b0);

    // R8: chip erase
    prefix5();
    wr(12'h555, 8'h10);
    chk("R8 chip start", {busy, erase_start, win_open}, 3'b110);
    chk("R8 chip mask", erase_mask, {NS{1'b1}});
    finish_erase(4);

    // R4 random sets
    for (int it = 0; it < 30; it++) begin
      int n;
      n = $urandom_range(1, 6);
      m = '0;
      prefix5();
      for (int k = 0; k < n; k++) begin
        s0 = $urandom_range(0, NS - 1);
        s1 = $urandom_range(0, 255);
        if (k > 0) repeat ($urandom_range(0, T - 2)) @(negedge clk);
        wr(sect_addr(s0, s1), 8'h30);
        m |= bit_of(s0);
      end
      expect_start("R4 random", m);
      if ($urandom_range(0, 1) == 1) begin
        wr(sect_addr($urandom_range(0, NS - 1), 0), 8'(32'($urandom_range(0, 255))));
        chk("R9 random busy write", erase_mask, m);
      end
      finish_erase($urandom_range(0, 20));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule